// File: doc/BRIEF.md
# Banked Register Store with Write-Busy Tracking

This block holds sixteen 8-bit setting registers, organised as four banks of four, on behalf of a serial command front end in front of a digitally controlled potentiometer. The registers stand in for nonvolatile storage: their contents start from a reset value, and every store into them behaves like a slow programming cycle. The front end decodes the serial frame and hands the store single-cycle strobes. It marks the start and the end of each frame, it signals when a complete data byte or a wiper-to-register transfer has been decoded, and it asks for a register-to-wiper load.

A store is not applied when its byte arrives. It waits as a pending request until the frame closes. At that point it is checked against the write-protect input. If it is accepted, a write-in-progress flag is raised for a fixed number of clock cycles. The register takes its new value on the same edge that the flag drops. While the flag is raised, reads return the old contents and any new store requests are discarded.

Register exchange with the wiper counter is limited to bank 0, in both directions. Bank 0 register 0 is always presented on a separate output, so that the wiper can be initialised from it at power-up.

Top module: `banked_nv_store`

## Requirements
- R1: After reset every register reads RESET_VAL, `wip` is 0 and `wiperLoad` is 0.
- R2: `rdData` shows the register at index bankSel*4+regSel in the same cycle, with no clock edge between.
- R3: A pending store is committed only by a `frameEnd` pulse. A frame that closes before any data byte or transfer strobe has arrived leaves every register unchanged and `wip` at 0.
- R4: An accepted commit raises `wip` on the clock edge that samples `frameEnd`. The flag stays high for exactly BUSY_CYCLES cycles. The target register changes on the edge where `wip` falls, and until then it reads its old value.
- R5: If `wpN` is 0 when `frameEnd` is sampled, the pending store is dropped: `wip` stays 0 and no register changes.
- R6: While `wip` is 1, `wrReq` and `storeReq` are ignored. A frame that opens and closes during that time commits nothing.
- R7: `storeReq` captures `wiperIn` as a store to register regSel of bank 0. With `bankSel` other than 0 it is ignored.
- R8: `loadReq` with `bankSel` 0 produces a one-cycle `wiperLoad` pulse on the next edge, with `wiperLoadVal` equal to register regSel of bank 0. With any other bank, no pulse is produced.
- R9: `recallVal` always equals bank 0 register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Pulse: a command frame has opened; discards any pending store |
| frameEnd | input | 1 | Pulse: a command frame has closed; commits a pending store |
| wrReq | input | 1 | Pulse: a data byte for the addressed register is complete |
| storeReq | input | 1 | Pulse: transfer the wiper value into a bank 0 register |
| loadReq | input | 1 | Pulse: load a bank 0 register into the wiper |
| bankSel | input | 2 | Bank address |
| regSel | input | 2 | Register address within the bank |
| wrData | input | 8 | Data byte for `wrReq` |
| wiperIn | input | 8 | Current wiper counter value for `storeReq` |
| wpN | input | 1 | Write protect, active low |
| rdData | output | 8 | Contents of the addressed register |
| wip | output | 1 | Write-in-progress flag |
| recallVal | output | 8 | Bank 0 register 0, used for power-up recall |
| wiperLoad | output | 1 | One-cycle pulse that loads the wiper counter |
| wiperLoadVal | output | 8 | Value to load into the wiper counter |

## Verification
Some properties are checked on every cycle. A commit is never started when write protect is low at frame close. No store is ever pending while the busy flag is up. The busy flag always drops right after the commit strobe. A wiper load pulse always traces back to a bank 0 load request. The recall output changes only on a commit.

Other behaviour can only be shown by the bench's scenarios. These are the exact length of the busy window and the old-versus-new read values around it. They also include discarding a whole frame issued during a busy window, refusing transfers to banks 1 to 3, and leaving registers untouched after a truncated frame. The bench checks these against a reference array of expected register contents, using a random mix of frames.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic commit;   // write commitData into register commitIdx this edge
    logic load;     // capture addressed bank 0 register for the wiper
  } nvsStrobe_t;
endpackage

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int BANKS         = 4,
  parameter int REGS_PER_BANK = 4,
  parameter int DATA_W        = 8,
  parameter int BUSY_CYCLES   = 1000000,
  localparam int BANK_W  = $clog2(BANKS),
  localparam int REG_W   = $clog2(REGS_PER_BANK),
  localparam int ENTRIES = BANKS * REGS_PER_BANK,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int CNT_W   = $clog2(BUSY_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              frameEnd,
  input  logic              wrReq,
  input  logic              storeReq,
  input  logic              loadReq,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [REG_W-1:0]  regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] wiperIn,
  input  logic              wpN,
  output logic [IDX_W-1:0]  reqIdx,
  output logic [IDX_W-1:0]  commitIdx,
  output logic [DATA_W-1:0] commitData,
  output logic              wip,
  output nvsStrobe_t        stb
);

  logic             pendValid;
  logic [CNT_W-1:0] busyCnt;
  logic             bankZero;
  logic             startCommit;

  assign reqIdx      = IDX_W'(bankSel) * IDX_W'(REGS_PER_BANK) + IDX_W'(regSel);
  assign bankZero    = (bankSel == '0);
  assign startCommit = frameEnd && pendValid && wpN && !wip;

  // Pending store capture; a frame boundary always clears it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid  <= 1'b0;
      commitIdx  <= '0;
      commitData <= '0;
    end else if (frameStart || frameEnd) begin
      pendValid <= 1'b0;
    end else if (!wip && wrReq) begin
      pendValid  <= 1'b1;
      commitIdx  <= reqIdx;
      commitData <= wrData;
    end else if (!wip && storeReq && bankZero) begin
      pendValid  <= 1'b1;
      commitIdx  <= reqIdx;
      commitData <= wiperIn;
    end
  end

  // Busy timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wip     <= 1'b0;
      busyCnt <= '0;
    end else if (startCommit) begin
      wip     <= 1'b1;
      busyCnt <= CNT_W'(BUSY_CYCLES);
    end else if (wip) begin
      if (busyCnt == CNT_W'(1)) wip <= 1'b0;
      else                      busyCnt <= busyCnt - CNT_W'(1);
    end
  end

  always_comb begin
    stb.commit = wip && (busyCnt == CNT_W'(1));
    stb.load   = loadReq && bankZero;
  end

  initial begin
    if (BUSY_CYCLES < 1) $error("BUSY_CYCLES must be at least 1");
  end

  a_r5_wp_blocks_commit: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && !wpN && !wip) |=> !wip);

  a_r6_nothing_pending_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    wip |-> !pendValid);

  a_r4_flag_drops_after_commit: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> !wip);

endmodule

// File: rtl/nvs_datapath.sv
module nvs_datapath
  import nvs_pkg::*;
#(
  parameter int BANKS         = 4,
  parameter int REGS_PER_BANK = 4,
  parameter int DATA_W        = 8,
  parameter logic [DATA_W-1:0] RESET_VAL = '0,
  localparam int ENTRIES = BANKS * REGS_PER_BANK,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  nvsStrobe_t        stb,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic [IDX_W-1:0]  commitIdx,
  input  logic [DATA_W-1:0] commitData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] recallVal,
  output logic              wiperLoad,
  output logic [DATA_W-1:0] wiperLoadVal
);

  logic [DATA_W-1:0] regFile [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) regFile[i] <= RESET_VAL;
    end else if (stb.commit) begin
      regFile[commitIdx] <= commitData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wiperLoad    <= 1'b0;
      wiperLoadVal <= '0;
    end else begin
      wiperLoad <= stb.load;
      if (stb.load) wiperLoadVal <= regFile[reqIdx];
    end
  end

  assign rdData    = regFile[reqIdx];
  assign recallVal = regFile[0];

  a_r9_recall_only_moves_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(recallVal));

  a_r8_load_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    wiperLoad |-> $past(stb.load));

endmodule

// File: rtl/banked_nv_store.sv
module banked_nv_store
  import nvs_pkg::*;
#(
  parameter int BANKS         = 4,
  parameter int REGS_PER_BANK = 4,
  parameter int DATA_W        = 8,
  parameter int BUSY_CYCLES   = 1000000,
  parameter logic [DATA_W-1:0] RESET_VAL = 8'h80,
  localparam int BANK_W  = $clog2(BANKS),
  localparam int REG_W   = $clog2(REGS_PER_BANK),
  localparam int IDX_W   = $clog2(BANKS * REGS_PER_BANK)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              frameEnd,
  input  logic              wrReq,
  input  logic              storeReq,
  input  logic              loadReq,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [REG_W-1:0]  regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] wiperIn,
  input  logic              wpN,
  output logic [DATA_W-1:0] rdData,
  output logic              wip,
  output logic [DATA_W-1:0] recallVal,
  output logic              wiperLoad,
  output logic [DATA_W-1:0] wiperLoadVal
);

  nvsStrobe_t        stb;
  logic [IDX_W-1:0]  reqIdx;
  logic [IDX_W-1:0]  commitIdx;
  logic [DATA_W-1:0] commitData;

  nvs_ctrl #(
    .BANKS(BANKS), .REGS_PER_BANK(REGS_PER_BANK),
    .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameEnd(frameEnd),
    .wrReq(wrReq), .storeReq(storeReq), .loadReq(loadReq),
    .bankSel(bankSel), .regSel(regSel), .wrData(wrData), .wiperIn(wiperIn),
    .wpN(wpN), .reqIdx(reqIdx), .commitIdx(commitIdx), .commitData(commitData),
    .wip(wip), .stb(stb)
  );

  nvs_datapath #(
    .BANKS(BANKS), .REGS_PER_BANK(REGS_PER_BANK),
    .DATA_W(DATA_W), .RESET_VAL(RESET_VAL)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .reqIdx(reqIdx),
    .commitIdx(commitIdx), .commitData(commitData),
    .rdData(rdData), .recallVal(recallVal),
    .wiperLoad(wiperLoad), .wiperLoadVal(wiperLoadVal)
  );

endmodule

// File: tb/tb_banked_nv_store.sv
module tb_banked_nv_store;
  localparam int BUSY = 12;
  localparam logic [7:0] RV = 8'h5A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 0, frameEnd = 0, wrReq = 0, storeReq = 0, loadReq = 0;
  logic [1:0] bankSel = 0, regSel = 0;
  logic [7:0] wrData = 0, wiperIn = 0;
  logic wpN = 1'b1;
  logic [7:0] rdData, recallVal, wiperLoadVal;
  logic wip, wiperLoad;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] model [16];

  always #4 clk = ~clk;

  banked_nv_store #(.BUSY_CYCLES(BUSY), .RESET_VAL(RV)) dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameEnd(frameEnd),
    .wrReq(wrReq), .storeReq(storeReq), .loadReq(loadReq),
    .bankSel(bankSel), .regSel(regSel), .wrData(wrData), .wiperIn(wiperIn),
    .wpN(wpN), .rdData(rdData), .wip(wip), .recallVal(recallVal),
    .wiperLoad(wiperLoad), .wiperLoadVal(wiperLoadVal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int idxOf(input logic [1:0] b, input logic [1:0] r);
    return int'(b) * 4 + int'(r);
  endfunction

  function automatic bit expectCommit(input bit complete, input bit wp, input bit store,
                                      input logic [1:0] b);
    return complete && wp && (!store || b == 2'd0);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic frameOp(input logic [1:0] b, input logic [1:0] r, input logic [7:0] d,
                         input bit complete, input bit wp, input bit store);
    int ix = idxOf(b, r);
    logic [7:0] old = model[ix];
    string tag;
    @(negedge clk); frameStart = 1; bankSel = b; regSel = r;
    @(negedge clk); frameStart = 0;
    if (complete) begin
      if (store) begin storeReq = 1; wiperIn = d; end
      else begin wrReq = 1; wrData = d; end
    end
    @(negedge clk); wrReq = 0; storeReq = 0; wpN = wp; frameEnd = 1;
    @(negedge clk); frameEnd = 0; wpN = 1;
    if (expectCommit(complete, wp, store, b)) begin
      chk("R4 wip raised", wip, 1);
      for (int k = 1; k < BUSY; k++) @(negedge clk);
      chk("R4 wip held", wip, 1);
      chk("R4 old during busy", rdData, old);
      @(negedge clk);
      chk("R4 wip dropped", wip, 0);
      chk(store ? "R7 store committed" : "R4 new value", rdData, d);
      model[ix] = d;
    end else begin
      tag = (store && b != 0) ? "R7 bank refused" : (!complete ? "R3 truncated" : "R5 protected");
      chk(tag, wip, 0);
      chk(tag, rdData, old);
    end
    chk("R9 recall", recallVal, model[0]);
  endtask

  task automatic loadOp(input logic [1:0] b, input logic [1:0] r);
    @(negedge clk); loadReq = 1; bankSel = b; regSel = r;
    @(negedge clk); loadReq = 0;
    chk("R8 load pulse", wiperLoad, b == 0);
    if (b == 0) chk("R8 load value", wiperLoadVal, model[r]);
    @(negedge clk);
    chk("R8 pulse one cycle", wiperLoad, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) model[i] = RV;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 wip", wip, 0);
    chk("R1 wiperLoad", wiperLoad, 0);
    for (int i = 0; i < 16; i++) begin
      bankSel = 2'(i / 4); regSel = 2'(i % 4); #1;
      chk("R1 R2 reset read", rdData, RV);
    end

    // Directed corners
    frameOp(2'd0, 2'd0, 8'h11, 1, 1, 0);
    frameOp(2'd3, 2'd3, 8'hFF, 1, 1, 0);
    frameOp(2'd1, 2'd2, 8'h33, 0, 1, 0);
    frameOp(2'd2, 2'd1, 8'h44, 1, 0, 0);
    frameOp(2'd0, 2'd2, 8'h77, 1, 1, 1);
    frameOp(2'd2, 2'd2, 8'h88, 1, 1, 1);
    loadOp(2'd0, 2'd2);
    loadOp(2'd1, 2'd2);

    // R6: a full frame issued during the busy window is discarded
    @(negedge clk); frameStart = 1; bankSel = 0; regSel = 1;
    @(negedge clk); frameStart = 0; wrReq = 1; wrData = 8'hA5;
    @(negedge clk); wrReq = 0; frameEnd = 1;
    @(negedge clk); frameEnd = 0; frameStart = 1; bankSel = 2; regSel = 3;
    @(negedge clk); frameStart = 0; wrReq = 1; wrData = 8'hC3;
    @(negedge clk); wrReq = 0; frameEnd = 1;
    @(negedge clk); frameEnd = 0;
    repeat (BUSY) @(negedge clk);
    chk("R6 no second commit", wip, 0);
    #1; chk("R6 busy write ignored", rdData, model[idxOf(2, 3)]);
    bankSel = 0; regSel = 1; #1;
    chk("R6 first write kept", rdData, 8'hA5);
    model[1] = 8'hA5;

    // Random mix
    for (int n = 0; n < 150; n++) begin
      int op = $urandom_range(0, 5);
      logic [1:0] b = 2'($urandom_range(0, 3));
      logic [1:0] r = 2'($urandom_range(0, 3));
      if (op == 0) loadOp(b, r);
      else if (op == 1) begin
        @(negedge clk); bankSel = b; regSel = r; #1;
        chk("R2 read", rdData, model[idxOf(b, r)]);
      end else
        frameOp(b, r, 8'($urandom), $urandom_range(0, 4) != 0,
                $urandom_range(0, 3) != 0, op == 2);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule